// File: doc/BRIEF.md
# Shift-Register Key Schedule with Round Limiter

This block feeds a bit-serial lightweight cipher datapath with its round keys and tells it when to stop. An 80-bit key is captured into a linear feedback shift register. Each enabled round the register is advanced by two positions, and its two most significant bits are presented as that round's subkey pair.

Rounds are not counted with a binary counter. An 8-bit sparse-feedback shift register starts from a fixed seed and advances once per round. Processing ends on the round in which that register holds a precomputed terminal value, which gives exactly 254 rounds per block. The register's top bit is also exported, so the datapath can use it as an irregular per-round control bit.

The cipher's controller pulses the load input with the key, raises the round enable for every cycle in which the datapath consumes a round, and waits for the done pulse.

Top module: `kls_top`

## Requirements
- R1: After reset, busy_o and done_o are 0.
- R2: A cycle with load_i high captures key_i, with key bit 0 in register position 0. From the next cycle busy_o is 1, done_o is 0, subkey_o equals key_i[79:78] and irreg_o is 1, because the round register seed is 8'hFF.
- R3: Each accepted round (busy_o high, round_en_i high, load_i low) advances the key register twice. One step is a left shift that takes in bit0^bit19^bit30^bit67 at position 0. subkey_o always shows positions {79,78}.
- R4: While busy_o is high and round_en_i is low, subkey_o and irreg_o hold their values.
- R5: busy_o falls right after the 254th accepted round, and not before.
- R6: done_o is high for exactly one cycle, in the cycle after the 254th accepted round, and only then.
- R7: Each accepted round advances the round register once. It shifts left and takes in bit7^bit6^bit4^bit2 at bit 0. irreg_o shows bit 7.
- R8: load_i while busy restarts the schedule from the new key and the seed. A full 254 accepted rounds are then needed again before done_o.
- R9: round_en_i while idle has no effect: subkey_o stays, and busy_o and done_o stay 0.
- R10: When load_i and round_en_i are high in the same cycle, the load wins and no round is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture key and start a block |
| key_i | input | 80 | Cipher key |
| round_en_i | input | 1 | Take one round this cycle |
| subkey_o | output | 2 | Current round subkey pair, {pos79,pos78} |
| irreg_o | output | 1 | Round register top bit |
| busy_o | output | 1 | Schedule is running |
| done_o | output | 1 | One-cycle pulse after the last round |

## Verification
The bench models both shift registers arithmetically and compares the subkey and control bit on every round, for several keys and several enable duty patterns. A design with the wrong taps, a reversed shift or a single step per round would diverge within a few rounds. It counts accepted rounds to catch an off-by-one terminal value, which would drop busy at round 253 or 255. It also checks a done pulse that lasts two cycles, a mid-block reload that fails to reseed the round register, idle enables that leak into the state, and a load that loses to a simultaneous round.

// File: rtl/kls_pkg.sv
package kls_pkg;
    localparam int KEY_BITS = 80;
    localparam int KEY_TAP_A = 19;
    localparam int KEY_TAP_B = 30;
    localparam int KEY_TAP_C = 67;
    localparam int RND_BITS = 8;
    localparam logic [RND_BITS-1:0] RND_SEED = '1;

    typedef struct packed {
        logic busy;
        logic done;
    } ctl_t;

    function automatic logic [KEY_BITS-1:0] key_step(input logic [KEY_BITS-1:0] k);
        return {k[KEY_BITS-2:0], k[0] ^ k[KEY_TAP_A] ^ k[KEY_TAP_B] ^ k[KEY_TAP_C]};
    endfunction

    function automatic logic [RND_BITS-1:0] rnd_step(input logic [RND_BITS-1:0] r);
        return {r[RND_BITS-2:0], r[7] ^ r[6] ^ r[4] ^ r[2]};
    endfunction

    function automatic logic [RND_BITS-1:0] rnd_after(input int steps);
        logic [RND_BITS-1:0] r;
        r = RND_SEED;
        for (int i = 0; i < steps; i++) r = rnd_step(r);
        return r;
    endfunction
endpackage

// File: rtl/kls_key_lfsr.sv
module kls_key_lfsr
    import kls_pkg::*;
#(
    parameter int STEPS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [KEY_BITS-1:0] key,
    input  logic                adv,
    output logic [STEPS-1:0]    top
);
    logic [KEY_BITS-1:0] key_d, key_q;
    logic [KEY_BITS-1:0] chain [STEPS+1];

    assign chain[0] = key_q;
    generate
        for (genvar s = 0; s < STEPS; s++) begin : g_step
            assign chain[s+1] = key_step(chain[s]);
        end
    endgenerate

    always_comb begin
        key_d = key_q;
        if (load)     key_d = key;
        else if (adv) key_d = chain[STEPS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign top = key_q[KEY_BITS-1 -: STEPS];
endmodule

// File: rtl/kls_round_lfsr.sv
module kls_round_lfsr
    import kls_pkg::*;
#(
    parameter int ROUNDS = 254
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output logic at_last,
    output logic msb
);
    localparam logic [RND_BITS-1:0] TERMINAL = rnd_after(ROUNDS - 1);

    logic [RND_BITS-1:0] rnd_d, rnd_q;

    always_comb begin
        rnd_d = rnd_q;
        if (load)     rnd_d = RND_SEED;
        else if (adv) rnd_d = rnd_step(rnd_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd_q <= RND_SEED;
        else        rnd_q <= rnd_d;
    end

    assign at_last = (rnd_q == TERMINAL);
    assign msb     = rnd_q[RND_BITS-1];
endmodule

// File: rtl/kls_top.sv
module kls_top
    import kls_pkg::*;
#(
    parameter int ROUNDS = 254,
    parameter int STEPS  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [KEY_BITS-1:0] key_i,
    input  logic                round_en_i,
    output logic [STEPS-1:0]    subkey_o,
    output logic                irreg_o,
    output logic                busy_o,
    output logic                done_o
);
    ctl_t ctl_d, ctl_q;
    logic fire, at_last;

    assign fire = ctl_q.busy & round_en_i & ~load_i;

    kls_key_lfsr #(.STEPS(STEPS)) u_key (
        .clk(clk), .rst_n(rst_n), .load(load_i), .key(key_i),
        .adv(fire), .top(subkey_o)
    );

    kls_round_lfsr #(.ROUNDS(ROUNDS)) u_rnd (
        .clk(clk), .rst_n(rst_n), .load(load_i), .adv(fire),
        .at_last(at_last), .msb(irreg_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.done = 1'b0;
        if (load_i) begin
            ctl_d.busy = 1'b1;
        end else if (fire && at_last) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;
endmodule

// File: rtl/kls_checker.sv
module kls_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic [79:0] key_i,
    input logic        round_en_i,
    input logic [1:0]  subkey_o,
    input logic        irreg_o,
    input logic        busy_o,
    input logic        done_o
);
    assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o && !done_o && subkey_o == $past(key_i[79:78]) && irreg_o);

    assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !round_en_i && !load_i |=> $stable(subkey_o) && $stable(irreg_o) && busy_o);

    assert_busy_falls_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !load_i |=> !busy_o && !done_o && $stable(subkey_o));
endmodule

bind kls_top kls_checker u_kls_checker (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
    .round_en_i(round_en_i), .subkey_o(subkey_o), .irreg_o(irreg_o),
    .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_kls_top.sv
module tb_kls_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        load_i = 0;
    logic [79:0] key_i = '0;
    logic        round_en_i = 0;
    logic [1:0]  subkey_o;
    logic        irreg_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [79:0] mk;
    logic [7:0]  mr;

    kls_top dut (.*);

    always #5 clk = ~clk;

    function automatic logic [79:0] m_key1(input logic [79:0] k);
        logic [79:0] n;
        n = k << 1;
        n[0] = k[0] ^ k[19] ^ k[30] ^ k[67];
        return n;
    endfunction

    function automatic logic [7:0] m_rnd1(input logic [7:0] r);
        logic [7:0] n;
        n = r << 1;
        n[0] = r[7] ^ r[6] ^ r[4] ^ r[2];
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [79:0] k, input bit with_en);
        key_i = k; load_i = 1; round_en_i = with_en;
        tick();
        load_i = 0; round_en_i = 0;
        mk = k; mr = 8'hFF;
        check(busy_o === 1'b1, "R2 busy", {79'b0, busy_o}, 80'd1);
        check(done_o === 1'b0, "R2 done", {79'b0, done_o}, 80'd0);
        check(subkey_o === k[79:78], "R2 subkey", {78'b0, subkey_o}, {78'b0, k[79:78]});
        check(irreg_o === 1'b1, "R7 seed", {79'b0, irreg_o}, 80'd1);
    endtask

    // run rounds; mode 0 = every cycle, else enable skipped when cycle % mode == 0
    task automatic run_rounds(input int mode, input int count);
        int rounds = 0;
        int cyc = 0;
        while (rounds < count && cyc < 4000) begin
            bit en;
            en = (mode == 0) ? 1'b1 : ((cyc % mode) != 0);
            check(subkey_o === mk[79:78], "R3 subkey", {78'b0, subkey_o}, {78'b0, mk[79:78]});
            check(irreg_o === mr[7], "R7 irreg", {79'b0, irreg_o}, {79'b0, mr[7]});
            round_en_i = en;
            tick();
            round_en_i = 0;
            cyc++;
            if (en) begin
                mk = m_key1(m_key1(mk));
                mr = m_rnd1(mr);
                rounds++;
            end else begin
                check(subkey_o === mk[79:78], "R4 held", {78'b0, subkey_o}, {78'b0, mk[79:78]});
            end
            if (rounds < 254) begin
                check(busy_o === 1'b1, "R5 busy early", {79'b0, busy_o}, 80'd1);
                check(done_o === 1'b0, "R6 early done", {79'b0, done_o}, 80'd0);
            end
        end
    endtask

    task automatic finish_block();
        check(busy_o === 1'b0, "R5 busy after 254", {79'b0, busy_o}, 80'd0);
        check(done_o === 1'b1, "R6 done pulse", {79'b0, done_o}, 80'd1);
        tick();
        check(done_o === 1'b0, "R6 done one cycle", {79'b0, done_o}, 80'd0);
        check(busy_o === 1'b0, "R5 stays idle", {79'b0, busy_o}, 80'd0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        @(negedge clk);
        check(busy_o === 1'b0, "R1 busy", {79'b0, busy_o}, 80'd0);
        check(done_o === 1'b0, "R1 done", {79'b0, done_o}, 80'd0);
        tick();
        rst_n = 1;
        tick();
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 after release", {78'b0, busy_o, done_o}, 80'd0);

        // R3 R5 R6 R7 across keys and enable patterns
        do_load(80'h8000_0000_0000_0000_0001, 0); run_rounds(0, 254); finish_block();
        do_load('1, 3);                          run_rounds(3, 254); finish_block();
        do_load(80'hA5C3_1F0E_7D92_4B68_E1F7, 0); run_rounds(2, 254); finish_block();
        do_load(80'h0000_0000_0000_0008_0000, 0); run_rounds(5, 254); finish_block();

        // R9: enables while idle change nothing
        held = subkey_o;
        for (int i = 0; i < 6; i++) begin
            round_en_i = 1; tick(); round_en_i = 0;
            check(subkey_o === held, "R9 subkey", {78'b0, subkey_o}, {78'b0, held});
            check(busy_o === 1'b0 && done_o === 1'b0, "R9 flags", {78'b0, busy_o, done_o}, 80'd0);
        end

        // R8: restart mid-block
        do_load(80'h1234_5678_9ABC_DEF0_1357, 0);
        run_rounds(0, 100);
        do_load(80'hFEDC_BA98_7654_3210_0F0F, 0);
        run_rounds(0, 254); finish_block();

        // R10: load with simultaneous round enable while busy
        do_load(80'h0F0F_0F0F_0F0F_0F0F_0F0F, 0);
        run_rounds(0, 7);
        do_load(80'hC000_0000_0000_0000_0000, 1);
        check(subkey_o === 2'b11, "R10 load wins", {78'b0, subkey_o}, 80'd3);
        run_rounds(0, 254); finish_block();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule